// File: doc/BRIEF.md
# Lockout Pushbutton Debouncer

This block cleans up a single mechanical contact signal, such as a pushbutton, whose level chatters for a while after each press or release. It does not wait for the contact to settle. The first change seen after a quiet period is passed to the output at once. A counter-timed lockout then masks everything the contact does for a fixed number of clock cycles. The bounce interval is bounded by the worst case the designer expects, which in practice is several milliseconds of clock time.

The raw level first passes through a configurable synchronizer chain, two flops by default. It then feeds a four-state Moore machine. The states are quiet-low, locked-high, quiet-high and locked-low. The output is decoded from the state alone. The lockout counter is held cleared in both quiet states and counts only while the machine is locked. The lockout length `LOCK_CYCLES` is a parameter, and the counter width is derived from it. Every reset in the block is synchronous.

Top module: `bounce_lockout_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the synchronizer flops and the counter clear, and the machine enters quiet-low. `clean_out` reads 0 after that edge.
- R2: With the default two synchronizer stages, a rise of `raw_in` seen at edge k reaches the machine after edge k+1. In quiet-low, `clean_out` goes from 0 to 1 after edge k+2, that is, on the third edge after the change.
- R3: In quiet-high, a fall of `raw_in` reaches `clean_out` with the same three-edge latency. `clean_out` goes from 1 to 0.
- R4: After every output change, the machine stays locked for exactly `LOCK_CYCLES` cycles and ignores its input throughout. It then spends at least one cycle quiet. Two output changes are therefore at least `LOCK_CYCLES`+1 edges apart. A one-cycle pulse on `raw_in` gives changes exactly `LOCK_CYCLES`+1 edges apart.
- R5: A burst of toggles on `raw_in` that ends within `LOCK_CYCLES`-1 cycles of its first change, and that settles at the level of that first change, produces exactly one output transition.
- R6: If the synchronized input differs from `clean_out` when the lockout ends, the output follows it on the edge after the quiet cycle. A level that returned during the lockout is not lost.
- R7: In a quiet state, an input equal to `clean_out` changes neither the state nor the output, and the counter stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all flops |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Bouncing contact level, may be asynchronous |
| clean_out | output | 1 | Debounced level, decoded from the state |

## Verification
Two functions can meet in the same cycle:
- **End of lockout and a waiting input.** An input that differs from the output can arrive at the synchronizer exactly as the counter reaches its final count. A one-cycle pulse provokes this, and so do random bursts whose last toggle lands near the window's end. The case is judged by the edge distance between the two output changes and by the final level.
- **Reset and a running lockout.** Reset can fall in the middle of a lockout. Random one-cycle resets inside bounce bursts provoke this. The case is judged against a countdown model in the bench, which must show the output at 0 and the lockout abandoned.

// File: rtl/bounce_lockout_pkg.sv
package bounce_lockout_pkg;

  // Encoding of the debouncer state register.
  typedef enum logic [1:0] {
    ST_QUIET_LO = 2'd0,
    ST_LOCK_HI  = 2'd1,
    ST_QUIET_HI = 2'd2,
    ST_LOCK_LO  = 2'd3
  } lock_state_e;

  // Counter width for a lockout of n cycles, never below one bit.
  function automatic int lock_cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bl_sync.sv
module bl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q <= '0;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bl_lock_timer.sv
module bl_lock_timer #(
  parameter int LIMIT = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic             expired,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  assign expired = run && (count == LAST);

  // Cleared whenever not running and on the final count, so a quiet state always sees zero.
  always_ff @(posedge clk) begin
    if (rst || !run || expired) count <= '0;
    else                        count <= count + 1'b1;
  end

endmodule

// File: rtl/bl_lock_fsm.sv
module bl_lock_fsm
  import bounce_lockout_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic expired,
  output logic out_level,
  output logic locked
);

  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_QUIET_LO: if (level)   state_d = ST_LOCK_HI;
      ST_LOCK_HI:  if (expired) state_d = ST_QUIET_HI;
      ST_QUIET_HI: if (!level)  state_d = ST_LOCK_LO;
      ST_LOCK_LO:  if (expired) state_d = ST_QUIET_LO;
      default:                  state_d = ST_QUIET_LO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_QUIET_LO;
    else     state_q <= state_d;
  end

  // Moore outputs: state only.
  assign out_level = (state_q == ST_LOCK_HI) || (state_q == ST_QUIET_HI);
  assign locked    = (state_q == ST_LOCK_HI) || (state_q == ST_LOCK_LO);

endmodule

// File: rtl/bounce_lockout_filter.sv
module bounce_lockout_filter
  import bounce_lockout_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic clean_out
);

  localparam int CNT_W = lock_cnt_width(LOCK_CYCLES);

  logic             sync_q;
  logic             locked;
  logic             expired;
  logic [CNT_W-1:0] lock_cnt;

  bl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_q)
  );

  bl_lock_timer #(.LIMIT(LOCK_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (locked),
    .expired (expired),
    .count   (lock_cnt)
  );

  bl_lock_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .level     (sync_q),
    .expired   (expired),
    .out_level (clean_out),
    .locked    (locked)
  );

endmodule

// File: rtl/bounce_lockout_chk.sv
module bounce_lockout_chk #(
  parameter int LOCK_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             raw_in,
  input logic             clean_out,
  input logic             sync_q,
  input logic             locked,
  input logic [CNT_W-1:0] lock_cnt
);

  logic [1:0] warm;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      reset_clears_chk: assert (!clean_out && !locked && lock_cnt == '0);
    end
  end

  // R2
  sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (SYNC_STAGES == 2 && warm >= 2'd2) |-> (sync_q == $past(raw_in, 2)));

  // R4
  change_from_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !$stable(clean_out)) |-> (!$past(locked) && locked));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (lock_cnt <= CNT_W'(LOCK_CYCLES - 1)));

  // R6
  follow_after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && sync_q != clean_out) |=> (locked && clean_out == $past(sync_q)));

  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && sync_q == clean_out) |=> ($stable(clean_out) && !locked && lock_cnt == '0));

endmodule

bind bounce_lockout_filter bounce_lockout_chk #(
  .LOCK_CYCLES (LOCK_CYCLES),
  .SYNC_STAGES (SYNC_STAGES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .raw_in    (raw_in),
  .clean_out (clean_out),
  .sync_q    (sync_q),
  .locked    (locked),
  .lock_cnt  (lock_cnt)
);

// File: tb/tb_bounce_lockout_filter.sv
module tb_bounce_lockout_filter;

  localparam int DD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_in = 1'b0;
  logic clean_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Countdown reference model state.
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_out = 1'b0;
  int   m_rem = 0;

  // Transition monitor.
  int  cyc = 0;
  int  tr_n = 0;
  int  tr_last = 0, tr_prev = 0;
  logic prev_out = 1'b0;

  always #4 clk = ~clk;

  bounce_lockout_filter #(.LOCK_CYCLES(DD), .SYNC_STAGES(2)) dut (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw_in),
    .clean_out (clean_out)
  );

  function automatic logic model_next(input logic lvl, input logic out, input int rem);
    return (rem == 0 && lvl != out) ? lvl : out;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1'b0; m_s2 = 1'b0; m_out = 1'b0; m_rem = 0;
    end else begin
      if (m_rem > 0) begin
        m_rem = m_rem - 1;
      end else if (m_s2 != m_out) begin
        m_out = model_next(m_s2, m_out, m_rem);
        m_rem = DD;
      end
      m_s2 = m_s1;
      m_s1 = raw_in;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (clean_out !== prev_out) begin
      tr_n++;
      tr_prev = tr_last;
      tr_last = cyc;
    end
    prev_out = clean_out;
    check(cur_req, int'(clean_out), int'(m_out), "model compare");
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    tick(3);
    check("R1", int'(clean_out), 0, "output under reset");
    rst = 1'b0;
    tick(2);

    // R2: rise latency of three edges
    cur_req = "R2";
    raw_in = 1'b1;
    tick(2);
    check("R2", int'(clean_out), 0, "before third edge");
    tick(1);
    check("R2", int'(clean_out), 1, "after third edge");
    tick(DD + 4);

    // R3 and R5: fall followed by a short bounce burst
    cur_req = "R3";
    tr_n = 0;
    raw_in = 1'b0; tick(1);
    raw_in = 1'b1; tick(1);
    raw_in = 1'b0; tick(1);
    check("R3", int'(clean_out), 0, "fall after third edge");
    raw_in = 1'b1; tick(1);
    raw_in = 1'b0;
    tick(DD + 6);
    check("R5", tr_n, 1, "transitions from burst");
    check("R5", int'(clean_out), 0, "settled level");

    // R4 and R6: one-cycle pulse gives two changes DD+1 edges apart
    cur_req = "R6";
    tr_n = 0;
    raw_in = 1'b1; tick(1);
    raw_in = 1'b0;
    tick(DD + 8);
    check("R6", tr_n, 2, "transitions from pulse");
    check("R4", tr_last - tr_prev, DD + 1, "edges between changes");
    check("R6", int'(clean_out), 0, "level after pulse");

    // R7: steady input matching the output
    cur_req = "R7";
    tr_n = 0;
    tick(30);
    check("R7", tr_n, 0, "quiet low no change");
    raw_in = 1'b1;
    tick(DD + 6);
    tr_n = 0;
    tick(30);
    check("R7", tr_n, 0, "quiet high no change");
    check("R7", int'(clean_out), 1, "quiet high level");

    // R4 and R1: random bursts, levels and stray resets against the model
    cur_req = "R4";
    for (int seg = 0; seg < 400; seg++) begin
      int kind = $urandom_range(0, 3);
      if (kind == 0) begin
        int len = $urandom_range(1, DD - 1);
        for (int j = 0; j < len; j++) begin
          raw_in = ~raw_in;
          if ($urandom_range(0, 40) == 0) rst = 1'b1;
          tick(1);
          rst = 1'b0;
        end
      end else begin
        raw_in = $urandom_range(0, 1) == 1;
        tick($urandom_range(1, 3 * DD));
      end
    end

    cur_req = "R1";
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check("R1", int'(clean_out), 0, "output after final reset");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule